// File: doc/BRIEF.md
# Three-Mode Interrupt Control Unit

This unit decides when a processor core takes an interrupt and where execution goes next. It keeps two enable flip-flops: a live maskable-enable bit and a shadow bit that remembers it across a non-maskable interrupt. It also holds a two-bit mode register and a byte-wide vector-base register. The core's decoder drives single-cycle strobes for enable, disable, mode select, return-from-NMI and vector-base load. Interrupt sources drive a level maskable request and a non-maskable request, and a device supplies a byte on the data bus.

When an interrupt is taken, the unit pulses an acknowledge and registers a target address. A non-maskable interrupt always goes to a fixed handler. A maskable interrupt is handled in one of three ways, set by the mode:
- In mode 0, the bus byte is treated as an opcode. A one-byte restart opcode is decoded straight to its page-zero address. Any other opcode raises a flag telling the core to fetch and execute the opcode from the bus.
- In mode 1, the target is a fixed restart address.
- In mode 2, the target is a table address. Its upper byte is the vector base and its lower byte is the bus byte.

The stack push and the execution of the handler belong to the core.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, int_ack, nmi_ack, target_addr and fetch_bus are all 0. Both enable bits, the mode and the vector base are cleared. A maskable request is therefore not taken until an enable strobe arrives, and a later request in mode 0 or mode 2 shows mode 0 and a zero base.
- R2: The `ei` strobe sets the maskable-enable bit and `di` clears it. If both are given in one cycle, `di` wins. While the bit is 0, `int_req` is ignored and int_ack stays 0.
- R3: With the enable bit set, an active `int_req` sampled at a clock edge gives int_ack = 1 for exactly the following cycle. Taking the interrupt clears the enable bit, so a request that stays high is not taken again until another `ei`.
- R4: The non-maskable request is taken on its rising edge whatever the enable bit holds, and only once while it stays high. nmi_ack pulses for one cycle, target_addr becomes 0x0066 and fetch_bus becomes 0.
- R5: When the non-maskable and maskable requests are taken in the same cycle, only nmi_ack pulses. The maskable request is not taken in that cycle and is not taken afterwards either, because its enable bit is cleared.
- R6: Taking a non-maskable interrupt copies the enable bit into the shadow bit and then clears the enable bit. The `retn` strobe copies the shadow bit back into the enable bit.
- R7: The `im_set` strobe loads `im_val` into the mode register when the value is 0, 1 or 2. The value 3 is ignored and the previous mode stays in force.
- R8: In mode 0 the bus byte is checked against the restart pattern (bits 7:6 = 11 and bits 2:0 = 111).
  - If it matches, target_addr = bits 5:3 × 8 and fetch_bus = 0. A bus byte of 0xFF therefore gives 0x0038.
  - Any other byte gives fetch_bus = 1 and target_addr = 0.
- R9: In mode 1, target_addr = 0x0038 and fetch_bus = 0 for every bus byte.
- R10: In mode 2, target_addr = {vector base, bus byte} and fetch_bus = 0. The vector base is loaded from `base_data` by the `base_load` strobe.
- R11: target_addr and fetch_bus change only in the cycle after an interrupt is taken. They hold while no interrupt is taken, even if the bus byte or the mode changes.
- R12: When an interrupt is taken, that cycle's `ei` and `retn` strobes have no effect on the enable bit, which ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ei | input | 1 | Enable maskable interrupts (strobe) |
| di | input | 1 | Disable maskable interrupts (strobe) |
| im_set | input | 1 | Load the mode register (strobe) |
| im_val | input | 2 | Mode value: 0, 1 or 2 |
| retn | input | 1 | Return from non-maskable handler (strobe) |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive |
| int_req | input | 1 | Maskable request, level-sensitive |
| bus_byte | input | BYTE_W | Byte placed on the data bus by the device |
| base_load | input | 1 | Load the vector-base register (strobe) |
| base_data | input | BYTE_W | New vector-base value |
| int_ack | output | 1 | Maskable interrupt taken (one-cycle pulse) |
| nmi_ack | output | 1 | Non-maskable interrupt taken (one-cycle pulse) |
| target_addr | output | ADDR_W | Address where execution continues |
| fetch_bus | output | 1 | Core must execute the opcode from the bus |

## Verification
The bench builds the unit with its default parameters: an 8-bit bus byte, a 16-bit address, and handler addresses of 0x0066 and 0x0038. With a byte only 8 bits wide, all 256 bus values can be swept in each of the three modes. In mode 2 the vector base is reloaded with a varying value on every step, so every restart opcode and every table address is compared against arithmetic done in the bench. Directed sequences then cover the enable and shadow-bit transitions: a non-maskable interrupt followed by a return with the enable bit both set and clear, simultaneous requests, a held non-maskable request, and enable strobes that coincide with an accept.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        IM_OPCODE = 2'd0,
        IM_FIXED  = 2'd1,
        IM_TABLE  = 2'd2
    } im_mode_e;

    localparam logic [1:0] IM_RESERVED = 2'd3;

    // Single-byte restart opcode: 11 nnn 111
    function automatic logic is_restart(input logic [7:0] op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    endfunction

    // Page-zero address of a restart opcode: nnn * 8
    function automatic logic [5:0] restart_offset(input logic [7:0] op);
        return {op[5:3], 3'b000};
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_ctrl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              im_set,
    input  logic [1:0]        im_val,
    input  logic              base_load,
    input  logic [BYTE_W-1:0] base_data,
    output im_mode_e          mode_o,
    output logic [BYTE_W-1:0] base_o
);

    typedef struct packed {
        im_mode_e          mode;
        logic [BYTE_W-1:0] base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (im_set && (im_val != IM_RESERVED)) begin
            cfg_d.mode = im_mode_e'(im_val);
        end
        if (base_load) begin
            cfg_d.base = base_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mode <= IM_OPCODE;
            cfg_q.base <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign base_o = cfg_q.base;

    // R7: a legal mode value is loaded on the strobe
    a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (im_set && (im_val != IM_RESERVED)) |=> (cfg_q.mode == $past(im_val)));

    // R7: the reserved value leaves the mode as it was
    a_r7_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (im_set && (im_val == IM_RESERVED)) |=> $stable(cfg_q.mode));

    // R10: the base register follows its load strobe only
    a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_load |=> $stable(cfg_q.base));

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ei,
    input  logic di,
    input  logic retn,
    input  logic nmi_req,
    input  logic int_req,
    output logic nmi_take,
    output logic int_take
);

    typedef struct packed {
        logic en;        // live maskable enable
        logic shadow;    // copy kept across a non-maskable interrupt
        logic nmi_prev;  // previous sample of the non-maskable request
    } ena_t;

    ena_t ena_d, ena_q;

    logic nmi_edge;

    always_comb begin
        nmi_edge = nmi_req && !ena_q.nmi_prev;
        nmi_take = nmi_edge;
        int_take = int_req && ena_q.en && !nmi_edge;

        ena_d          = ena_q;
        ena_d.nmi_prev = nmi_req;
        if (nmi_edge) begin
            ena_d.shadow = ena_q.en;
            ena_d.en     = 1'b0;
        end else if (int_take) begin
            ena_d.en = 1'b0;
        end else if (retn) begin
            ena_d.en = ena_q.shadow;
        end else if (di) begin
            ena_d.en = 1'b0;
        end else if (ei) begin
            ena_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else begin
            ena_q <= ena_d;
        end
    end

    // R6: the shadow bit captures the enable bit and the enable bit clears
    a_r6_nmi_save: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> ((ena_q.shadow == $past(ena_q.en)) && !ena_q.en));

    // R6: a lone return restores the enable bit from the shadow bit
    a_r6_retn_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (retn && !nmi_take && !int_take) |=> (ena_q.en == $past(ena_q.shadow)));

    // R3 and R12: taking a maskable interrupt leaves the enable bit cleared
    a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> !ena_q.en);

    // R4: a held request is taken only once
    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> !nmi_take);

    // R2: di overrides ei when nothing else acts
    a_r2_di_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (di && !retn && !nmi_take && !int_take) |=> !ena_q.en);

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_ctrl_pkg::*;
#(
    parameter int              BYTE_W     = 8,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] NMI_ADDR   = 16'h0066,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = 16'h0038
) (
    input  logic              nmi_sel,
    input  im_mode_e          mode,
    input  logic [BYTE_W-1:0] base,
    input  logic [BYTE_W-1:0] bus_byte,
    output logic [ADDR_W-1:0] target,
    output logic              fetch
);

    localparam int TABLE_W = 2 * BYTE_W;

    logic [7:0]         opcode;
    logic [TABLE_W-1:0] table_addr;

    assign opcode     = bus_byte[7:0];
    assign table_addr = {base, bus_byte};

    always_comb begin
        target = '0;
        fetch  = 1'b0;
        if (nmi_sel) begin
            target = NMI_ADDR;
        end else begin
            unique case (mode)
                IM_OPCODE: begin
                    if (is_restart(opcode)) begin
                        target = ADDR_W'(restart_offset(opcode));
                    end else begin
                        fetch = 1'b1;
                    end
                end
                IM_FIXED: target = FIXED_ADDR;
                IM_TABLE: target = ADDR_W'(table_addr);
                default:  target = FIXED_ADDR;
            endcase
        end
    end

    // R8: a bus fetch is requested only for a non-restart opcode in mode 0
    a_r8_fetch_only_opcode: assert final (!fetch ||
        (!nmi_sel && (mode == IM_OPCODE) && !is_restart(opcode)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int              BYTE_W     = 8,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] NMI_ADDR   = 16'h0066,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ei,
    input  logic              di,
    input  logic              im_set,
    input  logic [1:0]        im_val,
    input  logic              retn,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              base_load,
    input  logic [BYTE_W-1:0] base_data,
    output logic              int_ack,
    output logic              nmi_ack,
    output logic [ADDR_W-1:0] target_addr,
    output logic              fetch_bus
);

    typedef struct packed {
        logic              int_ack;
        logic              nmi_ack;
        logic [ADDR_W-1:0] target;
        logic              fetch;
    } out_t;

    im_mode_e          mode;
    logic [BYTE_W-1:0] base;
    logic              nmi_take;
    logic              int_take;
    logic [ADDR_W-1:0] vec_target;
    logic              vec_fetch;
    out_t              out_d, out_q;

    irq_cfg_regs #(.BYTE_W(BYTE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .im_set    (im_set),
        .im_val    (im_val),
        .base_load (base_load),
        .base_data (base_data),
        .mode_o    (mode),
        .base_o    (base)
    );

    irq_enable_ctl u_ena (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei       (ei),
        .di       (di),
        .retn     (retn),
        .nmi_req  (nmi_req),
        .int_req  (int_req),
        .nmi_take (nmi_take),
        .int_take (int_take)
    );

    irq_vector_gen #(
        .BYTE_W     (BYTE_W),
        .ADDR_W     (ADDR_W),
        .NMI_ADDR   (NMI_ADDR),
        .FIXED_ADDR (FIXED_ADDR)
    ) u_vec (
        .nmi_sel  (nmi_take),
        .mode     (mode),
        .base     (base),
        .bus_byte (bus_byte),
        .target   (vec_target),
        .fetch    (vec_fetch)
    );

    always_comb begin
        out_d         = out_q;
        out_d.int_ack = int_take;
        out_d.nmi_ack = nmi_take;
        if (int_take || nmi_take) begin
            out_d.target = vec_target;
            out_d.fetch  = vec_fetch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign int_ack     = out_q.int_ack;
    assign nmi_ack     = out_q.nmi_ack;
    assign target_addr = out_q.target;
    assign fetch_bus   = out_q.fetch;

    // R5: at most one acknowledge at a time
    a_r5_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({int_ack, nmi_ack}) <= 1);

    // R4: a non-maskable acknowledge carries the fixed handler address
    a_r4_nmi_target: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |-> ((target_addr == NMI_ADDR) && !fetch_bus));

    // R9: mode 1 always lands on the fixed restart address
    a_r9_fixed_target: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && (mode == IM_FIXED)) |=> ((target_addr == FIXED_ADDR) && !fetch_bus));

    // R11: the target holds while nothing is taken
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_take && !nmi_take) |=> ($stable(target_addr) && $stable(fetch_bus)));

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ei = 1'b0, di = 1'b0, im_set = 1'b0, retn = 1'b0;
    logic [1:0]  im_val = 2'd0;
    logic        nmi_req = 1'b0, int_req = 1'b0, base_load = 1'b0;
    logic [7:0]  bus_byte = 8'h00, base_data = 8'h00;
    logic        int_ack, nmi_ack, fetch_bus;
    logic [15:0] target_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ei(ei), .di(di), .im_set(im_set),
        .im_val(im_val), .retn(retn), .nmi_req(nmi_req), .int_req(int_req),
        .bus_byte(bus_byte), .base_load(base_load), .base_data(base_data),
        .int_ack(int_ack), .nmi_ack(nmi_ack), .target_addr(target_addr),
        .fetch_bus(fetch_bus)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h want %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_ei();
        @(negedge clk); ei = 1'b1;
        @(negedge clk); ei = 1'b0;
    endtask

    task automatic do_di();
        @(negedge clk); di = 1'b1;
        @(negedge clk); di = 1'b0;
    endtask

    task automatic do_retn();
        @(negedge clk); retn = 1'b1;
        @(negedge clk); retn = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); im_set = 1'b1; im_val = m;
        @(negedge clk); im_set = 1'b0;
    endtask

    task automatic load_base(input logic [7:0] b);
        @(negedge clk); base_load = 1'b1; base_data = b;
        @(negedge clk); base_load = 1'b0;
    endtask

    // one-cycle maskable request; outputs of that edge are visible on return
    task automatic req_int(input logic [7:0] b);
        @(negedge clk); int_req = 1'b1; bus_byte = b;
        @(negedge clk); int_req = 1'b0;
    endtask

    task automatic req_nmi();
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
    endtask

    function automatic logic [16:0] expect_vec(input int m, input logic [7:0] b,
                                               input logic [7:0] base);
        // {fetch, target}
        if (m == 0) begin
            if (b[7:6] == 2'b11 && b[2:0] == 3'b111) return {1'b0, 16'(b[5:3]) * 16'd8};
            return {1'b1, 16'h0000};
        end
        if (m == 1) return {1'b0, 16'h0038};
        return {1'b0, base, b};
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang want finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [16:0] ev;
        logic [7:0]  bs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 int_ack", int_ack, 0);
        check("R1 nmi_ack", nmi_ack, 0);
        check("R1 target", target_addr, 0);
        check("R1 fetch", fetch_bus, 0);
        req_int(8'hFF);
        check("R1 enable cleared", int_ack, 0);
        do_ei();
        req_int(8'hD7);
        check("R1 mode 0 after reset", int_ack, 1);
        check("R1 mode 0 restart 0x10", target_addr, 16'h0010);
        set_mode(2'd2);
        do_ei();
        req_int(8'h34);
        check("R1 base zero", target_addr, 16'h0034);

        // R8/R9/R10: sweep every bus byte in each mode
        for (int m = 0; m < 3; m++) begin
            set_mode(2'(m));
            for (int b = 0; b < 256; b++) begin
                bs = 8'(b) ^ 8'h5A;
                if (m == 2) load_base(bs);
                do_ei();
                req_int(8'(b));
                ev = expect_vec(m, 8'(b), bs);
                check(m == 0 ? "R8 ack" : (m == 1 ? "R9 ack" : "R10 ack"), int_ack, 1);
                check(m == 0 ? "R8 target" : (m == 1 ? "R9 target" : "R10 target"),
                      target_addr, ev[15:0]);
                check(m == 0 ? "R8 fetch" : (m == 1 ? "R9 fetch" : "R10 fetch"),
                      fetch_bus, ev[16]);
            end
        end

        // R7: reserved mode value ignored
        set_mode(2'd1);
        set_mode(2'd3);
        do_ei();
        req_int(8'h00);
        check("R7 reserved ignored", target_addr, 16'h0038);

        // R11: hold while idle, despite bus and mode changes
        @(negedge clk);
        check("R11 ack pulse ends", int_ack, 0);
        bus_byte = 8'hC7;
        set_mode(2'd0);
        repeat (3) @(negedge clk);
        check("R11 target held", target_addr, 16'h0038);
        check("R11 fetch held", fetch_bus, 0);

        // R3: held request taken once
        do_ei();
        @(negedge clk); int_req = 1'b1; bus_byte = 8'hFF;
        @(negedge clk);
        check("R3 first ack", int_ack, 1);
        check("R3 0xFF restart", target_addr, 16'h0038);
        @(negedge clk);
        check("R3 no re-accept", int_ack, 0);
        int_req = 1'b0;

        // R2: enable/disable and both together
        do_ei(); do_di();
        req_int(8'hFF);
        check("R2 di masks", int_ack, 0);
        @(negedge clk); ei = 1'b1; di = 1'b1;
        @(negedge clk); ei = 1'b0; di = 1'b0;
        req_int(8'hFF);
        check("R2 di wins", int_ack, 0);

        // R4: NMI with enable clear, held high
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk);
        check("R4 nmi ack", nmi_ack, 1);
        check("R4 nmi target", target_addr, 16'h0066);
        check("R4 nmi fetch", fetch_bus, 0);
        @(negedge clk);
        check("R4 held no repeat", nmi_ack, 0);
        @(negedge clk); nmi_req = 1'b0;

        // R6: save and restore with enable set
        do_ei();
        req_nmi();
        check("R6 nmi ack", nmi_ack, 1);
        req_int(8'hFF);
        check("R6 enable cleared by nmi", int_ack, 0);
        do_retn();
        req_int(8'hFF);
        check("R6 retn restores 1", int_ack, 1);
        // R6: with enable clear
        do_di();
        req_nmi();
        do_retn();
        req_int(8'hFF);
        check("R6 retn restores 0", int_ack, 0);

        // R5: simultaneous requests
        do_ei();
        @(negedge clk); nmi_req = 1'b1; int_req = 1'b1; bus_byte = 8'hFF;
        @(negedge clk); nmi_req = 1'b0;
        check("R5 nmi wins", nmi_ack, 1);
        check("R5 no maskable ack", int_ack, 0);
        @(negedge clk);
        check("R5 maskable stays blocked", int_ack, 0);
        int_req = 1'b0;

        // R12: ei and retn during an accept
        do_ei();
        @(negedge clk); int_req = 1'b1; ei = 1'b1; bus_byte = 8'hFF;
        @(negedge clk); int_req = 1'b0; ei = 1'b0;
        check("R12 accept with ei", int_ack, 1);
        req_int(8'hFF);
        check("R12 ei lost", int_ack, 0);
        do_ei();
        req_nmi();
        do_ei();
        @(negedge clk); int_req = 1'b1; retn = 1'b1;
        @(negedge clk); int_req = 1'b0; retn = 1'b0;
        check("R12 accept with retn", int_ack, 1);
        req_int(8'hFF);
        check("R12 retn lost", int_ack, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule